// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block sits above the bit-timing layer of a single-wire bus slave and runs the addressing step that follows every bus reset. It takes write-slot bits from a `bit_in_valid`/`bit_in` strobe pair. It answers read slots on `rd_req` with a level on `rd_bit`, where 0 means pull the line low and 1 means release it. It compares both against a 64-bit identity given on the `id` port.

After a reset indication, the block collects an 8-bit command, least significant bit first. The command selects one of three actions. Addressing by identity receives 64 bits and selects the slave only on an exact match. The skip command selects the slave at once. The search command runs a triad for each identity bit: the slave sends the bit, then its complement, then receives the direction the master chose. Several slaves share the line and their outputs combine as a wired-AND, so the master can find each identity by elimination.

The `selected` output hands control to the memory-function layer. It stays high until the next bus reset. A slave that loses addressing ignores the bus until that reset.

Top module: `ow_rom_cmd`

## Requirements
- R1: After `rst_n` low or a `bus_reset` pulse, `selected` is 0, `rd_bit` is 1, and the block waits for a command byte.
- R2: The command byte is taken from the next 8 write bits, least significant bit first. The bit pattern 0xCC sent most significant bit first arrives as 0x33 and does not select the slave.
- R3: Command 0xCC sets `selected` in the cycle after the 8th command bit, with no identity bits received.
- R4: After command 0x55, 64 write bits are compared against `id[0]` through `id[63]` in that order. `selected` rises in the cycle after the 64th bit only if every bit matched.
- R5: After command 0x55, any mismatching bit makes the slave inactive. It never sets `selected` and answers every read with 1 until a bus reset.
- R6: After command 0xF0, each identity bit i (i = 0 to 63) takes three slots: a read slot answered with `id[i]`, a read slot answered with `~id[i]`, and a write slot that gives the direction. Writes during the two read phases are ignored, and reads during the write phase answer 1.
- R7: During search, a direction bit that differs from `id[i]` drops the slave. It then answers reads with 1 and is not selected until a bus reset.
- R8: A slave whose 64 search directions all equal its identity sets `selected` in the cycle after the last direction bit.
- R9: Any command byte other than 0x55, 0xCC or 0xF0 leaves the slave inactive. It is not selected and answers reads with 1 until a bus reset.
- R10: A `bus_reset` pulse in any state aborts the command in progress and restarts command collection from bit 0.
- R11: While selected, further write and read slots do not clear `selected`, and reads answer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle bus reset indication from the bit layer |
| bit_in_valid | input | 1 | One-cycle strobe of a completed write slot |
| bit_in | input | 1 | Value of the write slot |
| rd_req | input | 1 | One-cycle read slot request |
| id | input | 64 | Own identity, bit 0 sent first |
| rd_bit | output | 1 | Read slot response, 0 pulls the line low, valid while `rd_req` is high |
| selected | output | 1 | Slave addressed; control passes to the memory layer |

## Verification
The assertions assume the bit layer never raises `bit_in_valid` and `rd_req` in the same cycle. They also assume each strobe lasts one cycle. The bench drives every slot through one task per slot type, with an idle cycle between slots, so no two strobes coincide. Three slaves share the stimulus, and the bench wired-ANDs their responses. Identities are random except for two that differ only in the last bit, which forces a search discrepancy at the final position.

// File: rtl/ow_rom_cmd.sv
module ow_rom_cmd #(
  parameter int        ID_W       = 64,
  parameter logic [7:0] CMD_MATCH  = 8'h55,
  parameter logic [7:0] CMD_SKIP   = 8'hCC,
  parameter logic [7:0] CMD_SEARCH = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            bit_in_valid,
  input  logic            bit_in,
  input  logic            rd_req,
  input  logic [ID_W-1:0] id,
  output logic            rd_bit,
  output logic            selected
);
  localparam int CW = $clog2(ID_W);

  typedef enum logic [2:0] {S_CMD, S_MATCH, S_TRUE, S_COMP, S_DIR, S_SEL, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;

  wire       own  = id[cnt];
  wire       last = (cnt == CW'(ID_W - 1));
  wire [7:0] cmd  = {bit_in, sh[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_CMD;
      cnt <= '0;
      sh  <= '0;
    end else if (bus_reset) begin
      st  <= S_CMD;
      cnt <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_CMD: if (bit_in_valid) begin
          sh <= cmd;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            if (cmd == CMD_MATCH)       st <= S_MATCH;
            else if (cmd == CMD_SKIP)   st <= S_SEL;
            else if (cmd == CMD_SEARCH) st <= S_TRUE;
            else                        st <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_MATCH: if (bit_in_valid) begin
          if (bit_in != own) st <= S_WAIT;
          else if (last)     st <= S_SEL;
          else               cnt <= cnt + 1'b1;
        end
        S_TRUE: if (rd_req) st <= S_COMP;
        S_COMP: if (rd_req) st <= S_DIR;
        S_DIR: if (bit_in_valid) begin
          if (bit_in != own) st <= S_WAIT;
          else if (last)     st <= S_SEL;
          else begin
            cnt <= cnt + 1'b1;
            st  <= S_TRUE;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_bit   = (st == S_TRUE) ? own : (st == S_COMP) ? ~own : 1'b1;
  assign selected = (st == S_SEL);

  wire in_search = (st == S_TRUE) || (st == S_COMP);

  // R1
  bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!selected && rd_bit));

  // R11
  selection_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_reset) |=> selected);

  // R4
  select_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> ($past(bit_in_valid) && !$past(bus_reset)));

  // R7
  released_outside_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !in_search) |-> rd_bit);

  // R6
  index_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_in_valid && !bus_reset) |=> $stable(cnt));
endmodule

// File: tb/test_ow_rom_cmd.sv
`timescale 1ns/1ps
module test_ow_rom_cmd;
  logic clk = 0, rst_n = 0, bus_reset = 0, bit_in_valid = 0, bit_in = 0, rd_req = 0;
  logic [63:0] ids [3];
  logic r0, r1, r2, s0, s1, s2;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ow_rom_cmd i_ow_rom_cmd (.clk, .rst_n, .bus_reset, .bit_in_valid, .bit_in, .rd_req,
                           .id(ids[0]), .rd_bit(r0), .selected(s0));
  ow_rom_cmd i_peer1 (.clk, .rst_n, .bus_reset, .bit_in_valid, .bit_in, .rd_req,
                      .id(ids[1]), .rd_bit(r1), .selected(s1));
  ow_rom_cmd i_peer2 (.clk, .rst_n, .bus_reset, .bit_in_valid, .bit_in, .rd_req,
                      .id(ids[2]), .rd_bit(r2), .selected(s2));

  wire       line = r0 & r1 & r2;
  wire [2:0] sel  = {s2, s1, s0};

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); bit_in = b; bit_in_valid = 1;
    @(negedge clk); bit_in_valid = 0;
  endtask

  task automatic read_bit(output logic b);
    @(negedge clk); rd_req = 1; #1 b = line;
    @(negedge clk); rd_req = 0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_id(logic [63:0] v);
    for (int i = 0; i < 64; i++) send_bit(v[i]);
  endtask

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  function automatic logic [2:0] match_mask(logic [63:0] key);
    logic [2:0] m;
    for (int k = 0; k < 3; k++) m[k] = (ids[k] == key);
    return m;
  endfunction

  function automatic logic wand_bit(logic [2:0] act, int i, logic inv);
    logic v = 1;
    for (int k = 0; k < 3; k++) if (act[k]) v &= (ids[k][i] ^ inv);
    return v;
  endfunction

  task automatic search_pass(inout int last_disc, inout logic [63:0] rom, output logic [2:0] act);
    logic t, c, dir;
    int zero_at = -1;
    act = 3'b111;
    pulse_reset();
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(t);
      check(t == wand_bit(act, i, 0), "R6 true bit", t, wand_bit(act, i, 0));
      read_bit(c);
      check(c == wand_bit(act, i, 1), "R6 complement", c, wand_bit(act, i, 1));
      if (t != c) dir = t;
      else begin
        if (i < last_disc) dir = rom[i];
        else dir = (i == last_disc);
        if (!dir) zero_at = i;
      end
      rom[i] = dir;
      send_bit(dir);
      for (int k = 0; k < 3; k++) if (ids[k][i] != dir) act[k] = 0;
    end
    last_disc = zero_at;
  endtask

  initial begin
    logic b;
    logic [2:0] act, found;
    logic [63:0] rom, key;
    int ld;
    void'($urandom(32'd4242));
    ids[0] = {$urandom, $urandom};
    ids[1] = {$urandom, $urandom};
    ids[1][0] = ~ids[0][0];
    ids[2] = ids[1] ^ (64'd1 << 63);

    #12 rst_n = 1;
    @(negedge clk); #1;
    check(sel == 3'b000, "R1 reset selected", sel, 0);
    rd_req = 1; #0.1;
    check(line == 1'b1, "R1 reset rd_bit", line, 1);
    rd_req = 0;

    pulse_reset(); send_byte(8'hCC); #1;
    check(sel == 3'b111, "R3 skip selects", sel, 3'b111);
    send_byte(8'h5A); read_bit(b); #1;
    check(sel == 3'b111, "R11 stays selected", sel, 3'b111);
    check(b == 1'b1, "R11 read released", b, 1);

    pulse_reset(); #1;
    check(sel == 3'b000, "R1 bus_reset clears", sel, 0);

    for (int i = 0; i < 8; i++) send_bit(8'hCC >> (7 - i)); #1;
    check(sel == 3'b000, "R2 msb-first skip not decoded", sel, 0);

    for (int k = 0; k < 3; k++) begin
      pulse_reset(); send_byte(8'h55); send_id(ids[k]); #1;
      check(sel == match_mask(ids[k]), "R4 match selects one", sel, match_mask(ids[k]));
    end

    for (int n = 0; n < 6; n++) begin
      key = ids[$urandom_range(0, 2)];
      if (n % 2 == 0) key[$urandom_range(0, 63)] ^= 1'b1;
      pulse_reset(); send_byte(8'h55); send_id(key); #1;
      check(sel == match_mask(key), "R5 random match", sel, match_mask(key));
      read_bit(b);
      if (match_mask(key) == 3'b000) check(b == 1'b1, "R5 inactive read released", b, 1);
    end

    for (int n = 0; n < 4; n++) begin
      key[7:0] = 8'($urandom);
      if (key[7:0] == 8'h55 || key[7:0] == 8'hCC || key[7:0] == 8'hF0) key[7:0] = 8'h0F;
      pulse_reset(); send_byte(key[7:0]); send_byte(8'hCC); read_bit(b); #1;
      check(sel == 3'b000, "R9 unknown command inactive", sel, 0);
      check(b == 1'b1, "R9 read released", b, 1);
    end

    pulse_reset(); send_byte(8'h55); for (int i = 0; i < 20; i++) send_bit(ids[0][i]);
    pulse_reset(); send_byte(8'hCC); #1;
    check(sel == 3'b111, "R10 reset aborts match", sel, 3'b111);
    pulse_reset(); send_bit(1); send_bit(0); send_bit(1);
    pulse_reset(); send_byte(8'hCC); #1;
    check(sel == 3'b111, "R10 reset aborts command", sel, 3'b111);

    pulse_reset(); send_byte(8'hF0); read_bit(b);
    send_bit(~ids[0][0]); read_bit(b);
    check(b == wand_bit(3'b111, 0, 1), "R6 write ignored in read phase", b, wand_bit(3'b111, 0, 1));
    send_bit(ids[0][0]); read_bit(b);
    check(b == wand_bit(match_mask(ids[0]) | {2'b00, 1'b1} & 3'b001 | ({ids[2][0], ids[1][0]} == {2{ids[0][0]}} ? 3'b110 : {ids[2][0] == ids[0][0], ids[1][0] == ids[0][0], 1'b0}), 1, 0),
          "R7 survivors after first direction", b, 0);

    ld = -1; rom = '0; found = '0;
    for (int p = 0; p < 3; p++) begin
      search_pass(ld, rom, act); #1;
      check($countones(act) == 1, "R8 one survivor", act, 0);
      check(sel == act, "R8 survivor selected", sel, act);
      check(match_mask(rom) == act, "R7 found id", rom, 0);
      found |= act;
    end
    check(found == 3'b111, "R8 all ids found", found, 3'b111);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule